// File: doc/BRIEF.md
# Nine-Bit Serial Receiver with Line-Break Detection

This block receives asynchronous serial frames of eleven bit periods. Each frame has a low start bit, eight data bits sent least significant bit first, a ninth payload bit and a high stop bit. The receive line is resynchronised into the clock domain. It is then sampled under a 16x oversampling tick, which comes from an external baud source as a one-clock strobe.

When a frame completes, the block presents the byte and the ninth bit on separate outputs and pulses a valid strobe for one clock. The stop bit's value is not kept. Two sticky status flags record line faults:
- a framing error, raised when the stop bit is sampled low;
- a line break, raised when every bit period of a frame is sampled low.

A clear strobe removes both flags. A small control register can be written and read back. When the alias select input is high, the top bit of that register's readback shows the framing-error flag instead of the stored bit.

Top module: `serial_rx9`

## Requirements
- R1: For each received frame, rx_data holds the eight data bits (first received bit in bit 0) and rx_bit9 holds the ninth bit. rx_valid is high for exactly one clock per frame, and frames separated by a single stop bit are all received.
- R2: A frame starts on a falling edge of the synchronised line. If the line is high at the 8th tick after that edge, the event is discarded and no rx_valid pulse is produced.
- R3: After the start confirmation, each of the nine payload bits and the stop bit is sampled once, 16 ticks after the previous sample.
- R4: stat_rdata bit 0 (framing error) becomes 1 when the stop bit is sampled low. The byte and ninth bit of that frame are still delivered with an rx_valid pulse, and the stop value is stored nowhere.
- R5: stat_rdata bit 1 (break) becomes 1 when all eleven bit samples of a frame are low, and the framing error is set with it. A frame that has a high stop bit leaves the break flag at 0.
- R6: Both status flags stay set until a one-clock stat_clr pulse, which returns them to 0.
- R7: After a break, the line held low produces no further rx_valid pulse. Once the line returns high, the next frame is received normally.
- R8: ctrl_rdata bits 6..0 return the last value written with ctrl_we. Bit 7 returns the framing-error flag when fe_on_ctrl is 1, and returns the stored bit 7 when fe_on_ctrl is 0.
- R9: After a synchronous reset, rx_valid, rx_data, rx_bit9, stat_rdata and ctrl_rdata are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | Oversampling strobe, 16 per bit period |
| rxd | input | 1 | Serial receive line, idle high |
| stat_clr | input | 1 | Clears both status flags |
| ctrl_we | input | 1 | Write strobe for the control register |
| ctrl_wdata | input | CTRL_W | Control register write data |
| fe_on_ctrl | input | 1 | Selects framing error onto control bit 7 readback |
| rx_data | output | DATA_W | Received data byte |
| rx_bit9 | output | 1 | Received ninth bit |
| rx_valid | output | 1 | One-clock frame-complete strobe |
| stat_rdata | output | 2 | Status: bit 0 framing error, bit 1 break |
| ctrl_rdata | output | CTRL_W | Control register readback |

## Verification
A bit counter or tick counter that is off by one shifts every payload bit by one position, or samples near a bit edge. This shows up in rx_data and rx_bit9 in the very first frame of the vector table. A sequencer stuck outside idle shows as a missing rx_valid pulse within one frame time. Broken flag logic shows as status bits that fail to rise on the fault frame, or that drop before stat_clr on the next good frame. A bad readback multiplexer is visible at once on ctrl_rdata bit 7 as soon as fe_on_ctrl toggles.

// File: rtl/serial_rx9_pkg.sv
package serial_rx9_pkg;
  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_BITS,
    RX_STOP,
    RX_HOLD
  } rx_state_e;

  localparam int STAT_W   = 2;
  localparam int STAT_FE  = 0;
  localparam int STAT_BRK = 1;
endpackage

// File: rtl/rx9_sync.sv
module rx9_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout,
  output logic fall
);
  logic [STAGES-1:0] sr;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr   <= '1;
      prev <= 1'b1;
    end else begin
      sr   <= {sr[STAGES-2:0], din};
      prev <= sr[STAGES-1];
    end
  end

  assign dout = sr[STAGES-1];
  assign fall = prev & ~sr[STAGES-1];
endmodule

// File: rtl/rx9_frame.sv
module rx9_frame
  import serial_rx9_pkg::*;
#(
  parameter int OVS      = 16,
  parameter int DATA_W   = 8,
  parameter int BRK_BITS = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              line,
  input  logic              fall,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              bit9_o,
  output logic              fe_o,
  output logic              brk_o
);
  localparam int PAY_W = DATA_W + 1;
  localparam int CNT_W = $clog2(OVS);
  localparam int IDX_W = $clog2(PAY_W);
  localparam int ZW    = $clog2(BRK_BITS + 1);
  localparam int MID   = OVS / 2;

  rx_state_e         state;
  logic [CNT_W-1:0]  cnt;
  logic [IDX_W-1:0]  idx;
  logic [PAY_W-1:0]  shreg;
  logic [ZW-1:0]     zcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= RX_IDLE;
      cnt    <= '0;
      idx    <= '0;
      shreg  <= '0;
      zcnt   <= '0;
      done_o <= 1'b0;
      data_o <= '0;
      bit9_o <= 1'b0;
      fe_o   <= 1'b0;
      brk_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      fe_o   <= 1'b0;
      brk_o  <= 1'b0;
      case (state)
        RX_IDLE: begin
          if (fall) begin
            state <= RX_START;
            cnt   <= '0;
            zcnt  <= '0;
          end
        end
        RX_START: begin
          if (tick) begin
            if (cnt == CNT_W'(MID - 1)) begin
              cnt <= '0;
              if (!line) begin
                state <= RX_BITS;
                idx   <= '0;
                zcnt  <= ZW'(1);
              end else begin
                state <= RX_IDLE;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        RX_BITS: begin
          if (tick) begin
            if (cnt == CNT_W'(OVS - 1)) begin
              cnt   <= '0;
              shreg <= {line, shreg[PAY_W-1:1]};
              if (line) zcnt <= '0;
              else if (zcnt != ZW'(BRK_BITS)) zcnt <= zcnt + 1'b1;
              if (idx == IDX_W'(PAY_W - 1)) state <= RX_STOP;
              else idx <= idx + 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        RX_STOP: begin
          if (tick) begin
            if (cnt == CNT_W'(OVS - 1)) begin
              cnt    <= '0;
              done_o <= 1'b1;
              data_o <= shreg[DATA_W-1:0];
              bit9_o <= shreg[PAY_W-1];
              fe_o   <= ~line;
              if (!line && zcnt >= ZW'(BRK_BITS - 1)) begin
                brk_o <= 1'b1;
                state <= RX_HOLD;
              end else begin
                state <= RX_IDLE;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        RX_HOLD: begin
          if (line) state <= RX_IDLE;
        end
        default: state <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rx9_regs.sv
module rx9_regs
  import serial_rx9_pkg::*;
#(
  parameter int CTRL_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_fe,
  input  logic              set_brk,
  input  logic              clr,
  input  logic              ctrl_we,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  input  logic              alias_sel,
  output logic [STAT_W-1:0] stat_o,
  output logic [CTRL_W-1:0] ctrl_o
);
  logic [STAT_W-1:0] stat_q;
  logic [CTRL_W-1:0] ctrl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      ctrl_q <= '0;
    end else begin
      stat_q[STAT_FE]  <= set_fe  | (stat_q[STAT_FE]  & ~clr);
      stat_q[STAT_BRK] <= set_brk | (stat_q[STAT_BRK] & ~clr);
      if (ctrl_we) ctrl_q <= ctrl_wdata;
    end
  end

  assign stat_o = stat_q;
  assign ctrl_o = {(alias_sel ? stat_q[STAT_FE] : ctrl_q[CTRL_W-1]), ctrl_q[CTRL_W-2:0]};
endmodule

// File: rtl/serial_rx9.sv
module serial_rx9
  import serial_rx9_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int DATA_W      = 8,
  parameter int CTRL_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int BRK_BITS    = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick16,
  input  logic              rxd,
  input  logic              stat_clr,
  input  logic              ctrl_we,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  input  logic              fe_on_ctrl,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_bit9,
  output logic              rx_valid,
  output logic [1:0]        stat_rdata,
  output logic [CTRL_W-1:0] ctrl_rdata
);
  logic line_s, line_fall, fe_p, brk_p;

  rx9_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .din(rxd), .dout(line_s), .fall(line_fall)
  );

  rx9_frame #(.OVS(OVS), .DATA_W(DATA_W), .BRK_BITS(BRK_BITS)) frame_i (
    .clk(clk), .rst(rst), .tick(tick16), .line(line_s), .fall(line_fall),
    .done_o(rx_valid), .data_o(rx_data), .bit9_o(rx_bit9),
    .fe_o(fe_p), .brk_o(brk_p)
  );

  rx9_regs #(.CTRL_W(CTRL_W)) regs_i (
    .clk(clk), .rst(rst), .set_fe(fe_p), .set_brk(brk_p), .clr(stat_clr),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .alias_sel(fe_on_ctrl),
    .stat_o(stat_rdata), .ctrl_o(ctrl_rdata)
  );
endmodule

// File: rtl/serial_rx9_chk.sv
module serial_rx9_chk (
  input logic       clk,
  input logic       rst,
  input logic       rx_valid,
  input logic [1:0] stat_rdata,
  input logic       ctrl_top,
  input logic       fe_on_ctrl,
  input logic       stat_clr
);
  // R1
  valid_single_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);
  // R4
  fe_after_frame_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(stat_rdata[0]) |-> $past(rx_valid));
  // R5
  brk_with_fe_chk: assert property (@(posedge clk) disable iff (rst)
    stat_rdata[1] |-> stat_rdata[0]);
  // R6
  fe_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_rdata[0] && !stat_clr) |=> stat_rdata[0]);
  // R6
  brk_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_rdata[1] && !stat_clr) |=> stat_rdata[1]);
  // R8
  alias_view_chk: assert property (@(posedge clk) disable iff (rst)
    fe_on_ctrl |-> (ctrl_top == stat_rdata[0]));
  // R9
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!rx_valid && stat_rdata == 2'b00));
endmodule

bind serial_rx9 serial_rx9_chk chk_i (
  .clk(clk), .rst(rst), .rx_valid(rx_valid), .stat_rdata(stat_rdata),
  .ctrl_top(ctrl_rdata[CTRL_W-1]), .fe_on_ctrl(fe_on_ctrl), .stat_clr(stat_clr)
);

// File: tb/serial_rx9_tb.sv
`timescale 1ns/1ps
module serial_rx9_tb_top;
  localparam int DIV     = 4;
  localparam int BIT_CLK = 16 * DIV;

  // [9] stop bit value, [8:0] payload (bit 8 = ninth bit)
  localparam logic [9:0] VEC [0:5] = '{10'h2A5, 10'h35A, 10'h3FF, 10'h200, 10'h101, 10'h280};

  logic clk = 0, rst = 1, tick16 = 0, rxd = 1, stat_clr = 0, ctrl_we = 0, fe_on_ctrl = 0;
  logic [7:0] ctrl_wdata = 0;
  logic [7:0] rx_data, ctrl_rdata;
  logic rx_bit9, rx_valid;
  logic [1:0] stat_rdata;

  int checks = 0, failures = 0, vcnt = 0, wide = 0, tdiv = 0;
  logic [7:0] cap_data = 0;
  logic cap_b9 = 0, prev_v = 0;

  always #2.5 clk = ~clk;

  serial_rx9 dut_i (
    .clk(clk), .rst(rst), .tick16(tick16), .rxd(rxd), .stat_clr(stat_clr),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .fe_on_ctrl(fe_on_ctrl),
    .rx_data(rx_data), .rx_bit9(rx_bit9), .rx_valid(rx_valid),
    .stat_rdata(stat_rdata), .ctrl_rdata(ctrl_rdata)
  );

  always @(posedge clk) begin
    tdiv   <= (tdiv == DIV - 1) ? 0 : tdiv + 1;
    tick16 <= (tdiv == DIV - 1);
  end

  always @(negedge clk) begin
    if (rx_valid) begin
      vcnt++;
      cap_data = rx_data;
      cap_b9 = rx_bit9;
      if (prev_v) wide++;
    end
    prev_v = rx_valid;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk) rxd = b;
    repeat (BIT_CLK - 1) @(negedge clk);
  endtask

  task automatic send_frame(input logic [8:0] pay, input logic stop);
    send_bit(1'b0);
    for (int i = 0; i < 9; i++) send_bit(pay[i]);
    send_bit(stop);
  endtask

  task automatic clear_status();
    @(negedge clk) stat_clr = 1;
    @(negedge clk) stat_clr = 0;
  endtask

  task automatic write_ctrl(input logic [7:0] v);
    @(negedge clk) begin ctrl_we = 1; ctrl_wdata = v; end
    @(negedge clk) ctrl_we = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int v0;
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R9 reset state
    check(rx_valid == 0 && rx_data == 0 && rx_bit9 == 0, "R9 outputs", {rx_valid, rx_bit9, rx_data}, 0);
    check(stat_rdata == 0, "R9 status", stat_rdata, 0);
    check(ctrl_rdata == 0, "R9 ctrl", ctrl_rdata, 0);
    send_bit(1'b1);

    // R1 R3 R4 R5 vector table
    foreach (VEC[k]) begin
      clear_status();
      v0 = vcnt;
      send_frame(VEC[k][8:0], VEC[k][9]);
      send_bit(1'b1);
      check(vcnt == v0 + 1, "R1 one valid per frame", vcnt - v0, 1);
      check(cap_data == VEC[k][7:0], "R3 data byte", cap_data, VEC[k][7:0]);
      check(cap_b9 == VEC[k][8], "R1 ninth bit", cap_b9, VEC[k][8]);
      check(stat_rdata[0] == ~VEC[k][9], "R4 framing flag", stat_rdata[0], ~VEC[k][9]);
      check(stat_rdata[1] == 0, "R5 no break", stat_rdata[1], 0);
    end

    // R2 glitch shorter than half a bit
    clear_status();
    v0 = vcnt;
    @(negedge clk) rxd = 0;
    repeat (3 * DIV) @(negedge clk);
    rxd = 1;
    send_bit(1'b1); send_bit(1'b1);
    check(vcnt == v0, "R2 glitch discarded", vcnt - v0, 0);
    send_frame(9'h13C, 1'b1);
    send_bit(1'b1);
    check(vcnt == v0 + 1 && cap_data == 8'h3C && cap_b9 == 1, "R2 frame after glitch", cap_data, 8'h3C);

    // R1 back-to-back frames with one stop bit
    v0 = vcnt;
    send_frame(9'h011, 1'b1);
    send_frame(9'h1E7, 1'b1);
    send_bit(1'b1);
    check(vcnt == v0 + 2, "R1 back-to-back count", vcnt - v0, 2);
    check(cap_data == 8'hE7 && cap_b9 == 1, "R1 back-to-back data", {cap_b9, cap_data}, 9'h1E7);

    // R6 sticky framing error
    clear_status();
    send_frame(9'h055, 1'b0);
    send_bit(1'b1);
    send_frame(9'h066, 1'b1);
    send_bit(1'b1);
    check(stat_rdata[0] == 1, "R6 flag held over good frame", stat_rdata, 1);
    // R8 alias with stored bit 7 = 0
    write_ctrl(8'h35);
    @(negedge clk) fe_on_ctrl = 1;
    @(negedge clk);
    check(ctrl_rdata == 8'hB5, "R8 alias shows fe", ctrl_rdata, 8'hB5);
    fe_on_ctrl = 0;
    @(negedge clk);
    check(ctrl_rdata == 8'h35, "R8 stored bit shown", ctrl_rdata, 8'h35);
    clear_status();
    @(negedge clk);
    check(stat_rdata == 0, "R6 cleared by strobe", stat_rdata, 0);
    write_ctrl(8'hC3);
    @(negedge clk) fe_on_ctrl = 1;
    @(negedge clk);
    check(ctrl_rdata == 8'h43, "R8 alias hides stored bit", ctrl_rdata, 8'h43);
    fe_on_ctrl = 0;
    @(negedge clk);
    check(ctrl_rdata == 8'hC3, "R8 stored bit restored", ctrl_rdata, 8'hC3);

    // R5 R7 break: line low for 16 bit times
    v0 = vcnt;
    for (int i = 0; i < 16; i++) send_bit(1'b0);
    check(stat_rdata == 2'b11, "R5 break and fe set", stat_rdata, 3);
    check(vcnt == v0 + 1, "R7 single frame during break", vcnt - v0, 1);
    check(cap_data == 0 && cap_b9 == 0, "R5 break data", {cap_b9, cap_data}, 0);
    send_bit(1'b1); send_bit(1'b1);
    clear_status();
    v0 = vcnt;
    send_frame(9'h0A5, 1'b1);
    send_bit(1'b1);
    check(vcnt == v0 + 1 && cap_data == 8'hA5, "R7 receive after line high", cap_data, 8'hA5);
    check(stat_rdata == 0, "R6 no flags after good frame", stat_rdata, 0);

    check(wide == 0, "R1 valid pulse width", wide, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule